// File: doc/BRIEF.md
# Three-Level Active-Clamped Phase Leg Gate Sequencer

This block produces the six gate commands of one phase leg of a three-level inverter whose neutral clamp uses active switches. A modulator asks for a leg state: the positive rail, the negative rail, one of four neutral variants, or "any neutral". For "any neutral" a two-bit select picks the variant. The select lets a loss-balancing controller spread conduction and switching stress over different devices.

A request is taken only while the block is idle. The block then walks the gates from the present pattern to the target pattern one switch at a time, in a fixed order for each commutation path. A dead time separates every change. Transitions from the negative rail mirror those from the positive rail. A move between two neutral variants, or from one rail to the other, passes through an intermediate state. The block shows `busy` while a walk is in progress and reports the settled state.

Top module: `anpc_leg_sequencer`

## Requirements
- R1: After reset, the gates show the positive-rail pattern, `legState` is 0 and `busy` is low.
- R2: State codes are: 0 positive, 1 upper-1, 2 upper-2, 3 lower-1, 4 lower-2, 5 negative. Bit i-1 of `gateOut` drives switch Si. At rest the gate pattern matches `legState`: positive = S1,S2,S6 on; upper-1 = S2,S4,S5 on; upper-2 = S2,S5 on; lower-1 = S1,S3,S6 on; lower-2 = S3,S6 on; negative = S3,S4,S5 on. All other switches are off.
- R3: Each change of `gateOut` toggles exactly one switch. Within a transition, changes come exactly DEAD_CYC+1 cycles apart, and never closer.
- R4: The pattern with S2, S3, S5 and S6 all on never appears on `gateOut`.
- R5: Positive to upper-2 runs S1 off, S6 off, S5 on. Positive to upper-1 adds S4 on last. Upper-2 to positive runs S5 off, S1 on, S6 on. Upper-1 to positive runs S5 off, S1 on, S6 on, S4 off.
- R6: Positive to lower-1 runs S2 off, S3 on. Lower-1 to positive runs S3 off, S2 on. Positive to lower-2 runs S1 off, S2 off, S3 on. Lower-2 to positive runs S3 off, S2 on, S1 on.
- R7: Transitions between the negative rail and a neutral variant use the mirror of the positive-rail path to the mirrored variant. The mirror swaps S1/S4, S2/S3 and S5/S6, and swaps upper-1/lower-1 and upper-2/lower-2.
- R8: Request code 6 selects the neutral variant from `neuSel`: 0 upper-1, 1 upper-2, 2 lower-1, 3 lower-2. `neuSel` is sampled only in the cycle the request is accepted.
- R9: A move between two neutral variants first goes to a rail. Lower-1 and upper-2 go through the positive rail. Upper-1 and lower-2 go through the negative rail. A rail-to-rail move goes through the neutral variant that `neuSel` names at acceptance.
- R10: A request is ignored if it comes while busy, carries code 7, or targets the present state. `legState` takes the target value only when the last dead time ends.
- R11: The first gate change comes one cycle after the accepting edge. `busy` is high from the cycle after acceptance for N×(DEAD_CYC+1) cycles, where N is the number of switch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqState | input | 3 | Requested state code (0–5, 6 = neutral by select, 7 = none) |
| neuSel | input | 2 | Neutral variant for code 6 and rail-to-rail moves |
| gateOut | output | 6 | Gate commands, bit i-1 = Si |
| legState | output | 3 | Settled leg state code |
| busy | output | 1 | Transition in progress |

## Verification
A request accepted at edge E0 puts the first gate word out at E0+1. Word k follows at E0+1+k(DEAD_CYC+1). `busy` drops, and `legState` and the rest pattern update, DEAD_CYC edges after the last word. The bench plans each path from its own table of switch toggles and waits exactly that many edges before sampling on the falling edge. A monitor samples every falling edge. It counts cycles between gate changes to check single-switch steps and spacing, and it checks that the prohibited pattern never appears.

// File: rtl/anpc_leg_pkg.sv
package anpc_leg_pkg;

  localparam int NUM_SW    = 6;
  localparam int MAX_STEPS = 4;
  localparam int STEP_W    = $clog2(MAX_STEPS);
  localparam int LEN_W     = $clog2(MAX_STEPS + 1);

  typedef logic [NUM_SW-1:0] gateWord_t;

  typedef enum logic [2:0] {
    ST_POS = 3'd0,
    ST_UP1 = 3'd1,
    ST_UP2 = 3'd2,
    ST_LO1 = 3'd3,
    ST_LO2 = 3'd4,
    ST_NEG = 3'd5,
    ST_NEU = 3'd6,
    ST_RSV = 3'd7
  } legState_e;

  // one commutation path between a rail and a neutral variant
  typedef struct packed {
    legState_e rail;
    legState_e neu;
    logic      toNeu;
  } legPlan_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadGate;
    gateWord_t  gateVal;
    logic       loadState;
    legState_e  stateVal;
  } pathCmd_t;

  localparam gateWord_t FORBID_MASK = 6'b110110;

  function automatic gateWord_t statePattern(legState_e s);
    case (s)
      ST_POS:  return 6'b100011;
      ST_UP1:  return 6'b011010;
      ST_UP2:  return 6'b010010;
      ST_LO1:  return 6'b100101;
      ST_LO2:  return 6'b100100;
      ST_NEG:  return 6'b011100;
      default: return '0;
    endcase
  endfunction

  // swap S1/S4, S2/S3, S5/S6
  function automatic gateWord_t mirrorGate(gateWord_t g);
    return {g[4], g[5], g[0], g[1], g[2], g[3]};
  endfunction

  function automatic legState_e mirrorState(legState_e s);
    case (s)
      ST_POS:  return ST_NEG;
      ST_NEG:  return ST_POS;
      ST_UP1:  return ST_LO1;
      ST_LO1:  return ST_UP1;
      ST_UP2:  return ST_LO2;
      ST_LO2:  return ST_UP2;
      default: return s;
    endcase
  endfunction

  function automatic logic isRail(legState_e s);
    return (s == ST_POS) || (s == ST_NEG);
  endfunction

  function automatic logic isNeutral(legState_e s);
    return (s == ST_UP1) || (s == ST_UP2) || (s == ST_LO1) || (s == ST_LO2);
  endfunction

  function automatic legState_e neutralFromSel(logic [1:0] sel);
    case (sel)
      2'd0:    return ST_UP1;
      2'd1:    return ST_UP2;
      2'd2:    return ST_LO1;
      default: return ST_LO2;
    endcase
  endfunction

  function automatic legState_e viaRail(legState_e n);
    return ((n == ST_LO1) || (n == ST_UP2)) ? ST_POS : ST_NEG;
  endfunction

  // number of single-switch steps on the positive-side path
  function automatic logic [LEN_W-1:0] legLen(legState_e n);
    case (n)
      ST_UP1:  return LEN_W'(4);
      ST_LO1:  return LEN_W'(2);
      default: return LEN_W'(3);
    endcase
  endfunction

  // gate word after step k on the positive-side path (bit0 = S1)
  function automatic gateWord_t legWord(legState_e n, logic toNeu, logic [STEP_W-1:0] k);
    gateWord_t w;
    w = statePattern(ST_POS);
    if (toNeu) begin
      case (n)
        ST_UP1, ST_UP2:
          case (k)
            2'd0:    w = 6'b100010;
            2'd1:    w = 6'b000010;
            2'd2:    w = 6'b010010;
            default: w = 6'b011010;
          endcase
        ST_LO1:
          w = (k == 2'd0) ? 6'b100001 : 6'b100101;
        default:
          case (k)
            2'd0:    w = 6'b100010;
            2'd1:    w = 6'b100000;
            default: w = 6'b100100;
          endcase
      endcase
    end else begin
      case (n)
        ST_UP1:
          case (k)
            2'd0:    w = 6'b001010;
            2'd1:    w = 6'b001011;
            2'd2:    w = 6'b101011;
            default: w = 6'b100011;
          endcase
        ST_UP2:
          case (k)
            2'd0:    w = 6'b000010;
            2'd1:    w = 6'b000011;
            default: w = 6'b100011;
          endcase
        ST_LO1:
          w = (k == 2'd0) ? 6'b100001 : 6'b100011;
        default:
          case (k)
            2'd0:    w = 6'b100000;
            2'd1:    w = 6'b100010;
            default: w = 6'b100011;
          endcase
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/anpc_gate_path.sv
module anpc_gate_path
  import anpc_leg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pathCmd_t   cmd,
  input  logic       busy,
  output gateWord_t  gateOut,
  output legState_e  stateOut
);

  gateWord_t gateReg;
  legState_e stateReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gateReg  <= statePattern(ST_POS);
      stateReg <= ST_POS;
    end else begin
      if (cmd.loadGate)  gateReg  <= cmd.gateVal;
      if (cmd.loadState) stateReg <= cmd.stateVal;
    end
  end

  assign gateOut  = gateReg;
  assign stateOut = stateReg;

  // R4
  no_forbidden_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateReg & FORBID_MASK) != FORBID_MASK);

  // R3
  single_switch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateReg != $past(gateReg)) |-> ($countones(gateReg ^ $past(gateReg)) == 1));

  // R2
  rest_pattern_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (gateReg == statePattern(stateReg)));

endmodule

// File: rtl/anpc_seq_ctrl.sv
module anpc_seq_ctrl
  import anpc_leg_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [2:0]  reqState,
  input  logic [1:0]  neuSel,
  input  legState_e   curState,
  input  gateWord_t   gateObs,
  output pathCmd_t    cmd,
  output logic        busy
);

  localparam int DEAD_W = $clog2(DEAD_CYC + 1);
  localparam int GAP_W  = $clog2(DEAD_CYC + 2);

  typedef enum logic [1:0] {PH_IDLE, PH_STEP, PH_DEAD} ctrlPhase_e;

  ctrlPhase_e           phase;
  logic [STEP_W-1:0]    stepIdx;
  logic                 legSel;
  logic [DEAD_W-1:0]    deadCnt;
  legPlan_t             legA, legB;
  logic                 twoLegs;
  legState_e            finalSt;

  legState_e reqCode, tgtEff, viaR, selNeu;
  logic      planOk, acceptReq, planTwo;
  legPlan_t  planA, planB;

  // request decode and route planning
  always_comb begin
    reqCode = legState_e'(reqState);
    selNeu  = neutralFromSel(neuSel);
    tgtEff  = (reqCode == ST_NEU) ? selNeu : reqCode;
    planOk  = (reqCode != ST_RSV) && (tgtEff != curState);
    acceptReq = (phase == PH_IDLE) && reqValid && planOk;
    viaR    = viaRail(curState);

    planA.rail = ST_POS; planA.neu = ST_UP1; planA.toNeu = 1'b0;
    planB = planA;
    planTwo = 1'b0;
    if (isRail(curState) && isNeutral(tgtEff)) begin
      planA.rail = curState; planA.neu = tgtEff; planA.toNeu = 1'b1;
    end else if (isNeutral(curState) && isRail(tgtEff)) begin
      planA.rail = tgtEff; planA.neu = curState; planA.toNeu = 1'b0;
    end else if (isNeutral(curState)) begin
      planA.rail = viaR; planA.neu = curState; planA.toNeu = 1'b0;
      planB.rail = viaR; planB.neu = tgtEff;   planB.toNeu = 1'b1;
      planTwo = 1'b1;
    end else begin
      planA.rail = curState; planA.neu = selNeu; planA.toNeu = 1'b1;
      planB.rail = tgtEff;   planB.neu = selNeu; planB.toNeu = 1'b0;
      planTwo = 1'b1;
    end
  end

  // step word of the active leg, mirrored for the negative rail
  legPlan_t          legCur;
  legState_e         canonNeu;
  logic              onNeg;
  gateWord_t         rawWord, stepWord;
  logic [LEN_W-1:0]  curLen;
  logic              moreSteps, lastLeg;

  always_comb begin
    legCur    = legSel ? legB : legA;
    onNeg     = (legCur.rail == ST_NEG);
    canonNeu  = onNeg ? mirrorState(legCur.neu) : legCur.neu;
    rawWord   = legWord(canonNeu, legCur.toNeu, stepIdx);
    stepWord  = onNeg ? mirrorGate(rawWord) : rawWord;
    curLen    = legLen(canonNeu);
    moreSteps = (LEN_W'(stepIdx) + LEN_W'(1)) < curLen;
    lastLeg   = legSel || !twoLegs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      stepIdx <= '0;
      legSel  <= 1'b0;
      deadCnt <= '0;
      legA    <= '0;
      legB    <= '0;
      twoLegs <= 1'b0;
      finalSt <= ST_POS;
    end else begin
      case (phase)
        PH_IDLE: if (acceptReq) begin
          legA    <= planA;
          legB    <= planB;
          twoLegs <= planTwo;
          finalSt <= tgtEff;
          stepIdx <= '0;
          legSel  <= 1'b0;
          phase   <= PH_STEP;
        end
        PH_STEP: begin
          deadCnt <= DEAD_W'(DEAD_CYC - 1);
          phase   <= PH_DEAD;
        end
        default: begin
          if (deadCnt != '0) begin
            deadCnt <= deadCnt - 1'b1;
          end else if (moreSteps) begin
            stepIdx <= stepIdx + 1'b1;
            phase   <= PH_STEP;
          end else if (!lastLeg) begin
            legSel  <= 1'b1;
            stepIdx <= '0;
            phase   <= PH_STEP;
          end else begin
            phase   <= PH_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    cmd.loadGate  = (phase == PH_STEP);
    cmd.gateVal   = stepWord;
    cmd.loadState = (phase == PH_DEAD) && (deadCnt == '0) && !moreSteps && lastLeg;
    cmd.stateVal  = finalSt;
  end

  assign busy = (phase != PH_IDLE);

  // gap counter between observed gate changes, for the dead-time check
  gateWord_t        gatePrev;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gatePrev <= statePattern(ST_POS);
      gapCnt   <= GAP_W'(DEAD_CYC + 1);
    end else begin
      gatePrev <= gateObs;
      if (gateObs != gatePrev)
        gapCnt <= GAP_W'(1);
      else if (gapCnt < GAP_W'(DEAD_CYC + 1))
        gapCnt <= gapCnt + 1'b1;
    end
  end

  // R3
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateObs != gatePrev) |-> (gapCnt >= GAP_W'(DEAD_CYC + 1)));

  // R11
  gate_only_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_STEP) |=> $stable(gateObs));

  // R10
  state_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STEP) |=> $stable(curState));

endmodule

// File: rtl/anpc_leg_sequencer.sv
module anpc_leg_sequencer
  import anpc_leg_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [2:0] reqState,
  input  logic [1:0] neuSel,
  output logic [5:0] gateOut,
  output logic [2:0] legState,
  output logic       busy
);

  pathCmd_t  pathCmd;
  gateWord_t gateW;
  legState_e stateW;

  anpc_seq_ctrl #(.DEAD_CYC(DEAD_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqState (reqState),
    .neuSel   (neuSel),
    .curState (stateW),
    .gateObs  (gateW),
    .cmd      (pathCmd),
    .busy     (busy)
  );

  anpc_gate_path u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (pathCmd),
    .busy     (busy),
    .gateOut  (gateW),
    .stateOut (stateW)
  );

  assign gateOut  = gateW;
  assign legState = stateW;

endmodule

// File: tb/anpc_leg_sequencer_tb.sv
module anpc_leg_sequencer_tb;

  localparam int DEAD = 3;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqState = 3'd0;
  logic [1:0] neuSel = 2'd0;
  logic [5:0] gateOut;
  logic [2:0] legState;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int expCur = 0;
  bit done = 0;
  logic [5:0] expW [0:7];
  int expN;

  always #10 clk = ~clk;

  anpc_leg_sequencer #(.DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqState(reqState),
    .neuSel(neuSel), .gateOut(gateOut), .legState(legState), .busy(busy)
  );

  function automatic logic [5:0] expPattern(int s);
    case (s)
      0: return 6'b100011;
      1: return 6'b011010;
      2: return 6'b010010;
      3: return 6'b100101;
      4: return 6'b100100;
      5: return 6'b011100;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic int mirSw(int sw);
    case (sw)
      1: return 4; 4: return 1; 2: return 3; 3: return 2; 5: return 6; default: return 5;
    endcase
  endfunction

  function automatic int mirSt(int s);
    case (s)
      0: return 5; 5: return 0; 1: return 3; 3: return 1; 2: return 4; 4: return 2; default: return s;
    endcase
  endfunction

  function automatic int togCount(int n);
    return (n == 1) ? 4 : (n == 3) ? 2 : 3;
  endfunction

  // +sw = switch on, -sw = switch off, positive-rail side paths
  function automatic int togItem(int n, bit toNeu, int k);
    if (toNeu) begin
      case (n)
        1: case (k) 0: return -1; 1: return -6; 2: return 5; default: return 4; endcase
        2: case (k) 0: return -1; 1: return -6; default: return 5; endcase
        3: case (k) 0: return -2; default: return 3; endcase
        default: case (k) 0: return -1; 1: return -2; default: return 3; endcase
      endcase
    end else begin
      case (n)
        1: case (k) 0: return -5; 1: return 1; 2: return 6; default: return -4; endcase
        2: case (k) 0: return -5; 1: return 1; default: return 6; endcase
        3: case (k) 0: return -3; default: return 2; endcase
        default: case (k) 0: return -3; 1: return 2; default: return 1; endcase
      endcase
    end
  endfunction

  task automatic legExp(input int rail, input int neu, input bit toNeu, inout logic [5:0] g);
    int cn = (rail == 5) ? mirSt(neu) : neu;
    for (int k = 0; k < togCount(cn); k++) begin
      int t  = togItem(cn, toNeu, k);
      int sw = (t < 0) ? -t : t;
      if (rail == 5) sw = mirSw(sw);
      g[sw-1] = (t > 0);
      expW[expN] = g;
      expN++;
    end
  endtask

  task automatic planExp(input int cur, input int tgt, input int ns);
    logic [5:0] g = expPattern(cur);
    bit curRail = (cur == 0) || (cur == 5);
    bit tgtRail = (tgt == 0) || (tgt == 5);
    expN = 0;
    if (curRail && !tgtRail) legExp(cur, tgt, 1'b1, g);
    else if (!curRail && tgtRail) legExp(tgt, cur, 1'b0, g);
    else if (!curRail) begin
      int via = (cur == 3 || cur == 2) ? 0 : 5;   // R9 route rule
      legExp(via, cur, 1'b0, g);
      legExp(via, tgt, 1'b1, g);
    end else begin
      legExp(cur, ns + 1, 1'b1, g);
      legExp(tgt, ns + 1, 1'b0, g);
    end
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic runReq(input int code, input int ns, input string tag, input bit meddle);
    int tgt;
    bit ign;
    @(negedge clk);
    reqValid = 1'b1;
    reqState = 3'(code);
    neuSel   = 2'(ns);
    tgt = (code == 6) ? ns + 1 : code;
    ign = (code == 7) || (tgt == expCur);
    if (!ign) planExp(expCur, tgt, ns);
    @(posedge clk);
    @(negedge clk);
    reqValid = meddle && !ign;
    reqState = 3'((code == 0) ? 5 : 0);
    neuSel   = 2'($urandom);           // R8: later select changes are ignored
    if (ign) begin
      check("R10", 32'(busy), 32'd0);
      check("R10", 32'(legState), 32'(expCur));
      check("R10", 32'(gateOut), 32'(expPattern(expCur)));
      return;
    end
    check("R11", 32'(busy), 32'd1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, 32'(gateOut), 32'(expW[0]));
    for (int k = 1; k < expN; k++) begin
      repeat (DEAD + 1) @(posedge clk);
      @(negedge clk);
      check(tag, 32'(gateOut), 32'(expW[k]));
    end
    repeat (DEAD - 1) @(posedge clk);
    @(negedge clk);
    check("R11", 32'(busy), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check("R11", 32'(busy), 32'd0);
    check("R10", 32'(legState), 32'(tgt));
    check("R2", 32'(gateOut), 32'(expPattern(tgt)));
    expCur = tgt;
  endtask

  // monitor: single-switch steps, spacing, prohibited pattern
  logic [5:0] prevG = 6'b100011;
  int gap = 100;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      gap++;
      if (gateOut !== prevG) begin
        check("R3", 32'($countones(gateOut ^ prevG)), 32'd1);
        check("R3", 32'(gap >= DEAD + 1), 32'd1);
        gap = 0;
      end
      if ((gateOut & 6'b110110) == 6'b110110)
        check("R4", 32'(gateOut), 32'h0);
      prevG = gateOut;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(gateOut), 32'(expPattern(0)));
    check("R1", 32'(legState), 32'd0);
    check("R1", 32'(busy), 32'd0);

    runReq(2, 0, "R5", 0);
    runReq(0, 0, "R5", 0);
    runReq(1, 0, "R5", 0);
    runReq(0, 0, "R5", 0);
    runReq(3, 0, "R6", 0);
    runReq(0, 0, "R6", 0);
    runReq(4, 0, "R6", 0);
    runReq(0, 0, "R6", 0);
    runReq(5, 1, "R9", 0);
    runReq(1, 0, "R7", 0);
    runReq(5, 0, "R7", 0);
    runReq(4, 0, "R7", 0);
    runReq(6, 2, "R8", 0);
    runReq(6, 2, "R10", 0);
    runReq(7, 0, "R10", 0);
    runReq(0, 0, "R10", 1);
    runReq(6, 0, "R8", 0);
    runReq(6, 3, "R9", 1);

    for (int i = 0; i < 150; i++) begin
      int c = $urandom % 8;
      runReq(c, $urandom % 4, "R9", bit'($urandom % 2));
    end

    repeat (5) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule